// File: doc/BRIEF.md
# Four-Lane Quadrature Tone Generator

This block generates a digital tone, in sine and cosine form, for a mixer that handles four samples per clock. On every enabled clock it produces four consecutive phase points. Each point comes as a signed sine value and a signed cosine value. A single generator can serve several input channels when they all mix against the same tone.

A programmable phase increment sets the tone frequency. One phase accumulator advances by four increments per enabled clock. Four lane phases are derived from the accumulator, one increment apart. Each lane phase addresses a table that holds only the first quarter of a sine period. The full period is rebuilt from the two top phase bits:

- Mirroring the table address rebuilds the second half of each half-wave.
- Negating the magnitude rebuilds the negative half-wave.

Cosine is the same lookup taken a quarter period further on. The table reads are fully pipelined, so the block delivers one complete set of results per clock, and latency is fixed.

Top module: `quad_nco4`

## Requirements
- R1: During and immediately after reset, `vld` is 0 and `sin_o` and `cos_o` are all zero.
- R2: `vld` is 1 exactly four clock edges after an edge that sampled `en` high, and 0 otherwise. Each enabled cycle produces exactly one output set, with no gaps.
- R3: Lane k (k = 0..3) uses phase `acc + k*inc` (mod 2^16), where `acc` is the accumulator value before that edge. The accumulator advances by `4*inc` on each enabled edge and holds its value when `en` is low.
- R4: The quarter table has N = 256 entries. Entry i holds round(8191 * sin((pi/2) * i / 255)). The lookup address is phase bits [13:6].
- R5: Phase bits [15:14] give the quadrant. In quadrants 1 and 3 the address a is mirrored to 255 - a. In quadrants 2 and 3 the looked-up magnitude is negated. The result is the lane's sine.
- R6: A lane's cosine equals the R5 sine lookup of that lane's phase plus 16384 (mod 2^16).
- R7: When `clr` is high, the accumulator is treated as 0 for that edge. The first set produced afterwards has lane 0 at phase 0: sine 0 and cosine 8191.
- R8: `inc` is sampled on every enabled edge. A new value affects the lane offsets and the accumulator step of that same edge.
- R9: Lane k occupies bits [14k+13 : 14k] of `sin_o` and `cos_o`, in two's complement. Its magnitude never exceeds 8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the phase accumulator |
| en | input | 1 | Advance the accumulator and launch one output set |
| inc | input | 16 | Phase increment per sample |
| sin_o | output | 56 | Four packed signed sine values, lane 0 in the low bits |
| cos_o | output | 56 | Four packed signed cosine values, lane 0 in the low bits |
| vld | output | 1 | Output set is valid |

## Verification
The bench builds the block with its default parameters: 16-bit phase, 14-bit outputs and a 256-entry quarter table. At these sizes every table entry and every quadrant can be reached within a few hundred cycles.

The increments are chosen to cover specific cases:
- Increments of exactly a quarter period put all four lanes on quadrant edges, where mirroring and sign selection matter most.
- An increment of 0xFFFF walks the phase backwards through the wrap.
- Random increments that change every cycle test that the increment is sampled on the same edge.
- Gaps in `en` and lone clears test that the accumulator holds and restarts at phase 0.

// File: rtl/quad_nco4.sv
module quad_nco4 #(
  parameter int PHASE_W = 16,
  parameter int OUT_W   = 14,
  parameter int TAB_AW  = 8,
  parameter int LANES   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     en,
  input  logic [PHASE_W-1:0]       inc,
  output logic [LANES*OUT_W-1:0]   sin_o,
  output logic [LANES*OUT_W-1:0]   cos_o,
  output logic                     vld
);

  localparam int TAB_N = 1 << TAB_AW;
  localparam int MAG_W = OUT_W - 1;
  localparam int FS    = (1 << (OUT_W - 1)) - 1;
  localparam int LAT   = 4;

  function automatic int qval(input int i);
    real x;
    x = 1.5707963267948966 * real'(i) / real'(TAB_N - 1);
    return $rtoi(real'(FS) * $sin(x) + 0.5);
  endfunction

  function automatic int mag_of(input logic signed [OUT_W-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  logic [MAG_W-1:0] qtab [TAB_N];
  for (genvar i = 0; i < TAB_N; i++) begin : g_tab
    assign qtab[i] = MAG_W'(qval(i));
  end

  logic [PHASE_W-1:0] acc, acc_eff;
  logic [LAT-1:0]     vpipe;

  assign acc_eff = clr ? '0 : acc;
  assign vld     = vpipe[LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      vpipe <= '0;
    end else begin
      acc   <= en ? acc_eff + PHASE_W'(LANES) * inc : acc_eff;
      vpipe <= {vpipe[LAT-2:0], en};
    end
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(acc));

  // R2
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ##4 vld);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> ##4 !vld);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PHASE_W-1:0] ph;
    logic [TAB_AW-1:0]  sa, ca;
    logic               sn, cn, sn2, cn2;
    logic [MAG_W-1:0]   sm, cm;
    logic [1:0]         sq, cq;
    logic signed [OUT_W-1:0] so, co;

    assign sq = ph[PHASE_W-1 -: 2];
    assign cq = sq + 2'd1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph  <= '0;
        sa  <= '0;
        ca  <= '0;
        sn  <= 1'b0;
        cn  <= 1'b0;
        sm  <= '0;
        cm  <= '0;
        sn2 <= 1'b0;
        cn2 <= 1'b0;
        so  <= '0;
        co  <= '0;
      end else begin
        ph  <= acc_eff + PHASE_W'(k) * inc;
        sa  <= sq[0] ? ~ph[PHASE_W-3 -: TAB_AW] : ph[PHASE_W-3 -: TAB_AW];
        ca  <= cq[0] ? ~ph[PHASE_W-3 -: TAB_AW] : ph[PHASE_W-3 -: TAB_AW];
        sn  <= sq[1];
        cn  <= cq[1];
        sm  <= qtab[sa];
        cm  <= qtab[ca];
        sn2 <= sn;
        cn2 <= cn;
        so  <= sn2 ? -$signed({1'b0, sm}) : $signed({1'b0, sm});
        co  <= cn2 ? -$signed({1'b0, cm}) : $signed({1'b0, cm});
      end
    end

    assign sin_o[k*OUT_W +: OUT_W] = so;
    assign cos_o[k*OUT_W +: OUT_W] = co;

    // R7
    if (k == 0) begin : g_clr
      clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ph == '0);
    end

    // R9
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> (mag_of(so) <= FS && mag_of(co) <= FS));

    // R6
    quad_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> (mag_of(so) + mag_of(co) >= FS - 1));
  end

endmodule

// File: tb/quad_nco4_tb.sv
module quad_nco4_tb;
  localparam int W  = 14;
  localparam int FS = 8191;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic en = 1'b0;
  logic [15:0] inc = '0;
  logic [4*W-1:0] sin_o, cos_o;
  logic vld;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  quad_nco4 u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .inc(inc),
    .sin_o(sin_o), .cos_o(cos_o), .vld(vld)
  );

  function automatic int tab(input int i);
    return $rtoi($floor(8191.0 * $sin(1.5707963267948966 * real'(i) / 255.0) + 0.5));
  endfunction

  function automatic int lk(input int ph);
    int p, q, a, m;
    p = ph & 16'hFFFF;
    q = p >> 14;
    a = (p >> 6) & 255;
    m = (q % 2 == 1) ? tab(255 - a) : tab(a);
    return (q >= 2) ? -m : m;
  endfunction

  int macc;
  bit ev [4];
  bit ef [4];
  int es [4][4];
  int ec [4][4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      macc = 0;
      for (int j = 0; j < 4; j++) begin
        ev[j] = 0; ef[j] = 0;
      end
    end else begin
      int ea;
      for (int j = 3; j > 0; j--) begin
        ev[j] = ev[j-1]; ef[j] = ef[j-1];
        for (int k = 0; k < 4; k++) begin
          es[j][k] = es[j-1][k]; ec[j][k] = ec[j-1][k];
        end
      end
      ea = clr ? 0 : macc;
      ev[0] = en;
      ef[0] = en && clr;
      for (int k = 0; k < 4; k++) begin
        es[0][k] = lk(ea + k * int'(inc));
        ec[0][k] = lk(ea + k * int'(inc) + 16384);
      end
      macc = en ? ((ea + 4 * int'(inc)) & 16'hFFFF) : ea;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lane(input logic [4*W-1:0] v, input int k);
    logic signed [W-1:0] s;
    s = v[k*W +: W];
    return int'(s);
  endfunction

  task automatic compare();
    chk(vld == ev[3], "R2 vld", int'(vld), int'(ev[3]));
    if (ev[3] && vld) begin
      for (int k = 0; k < 4; k++) begin
        // R3 R4 R5 R8 R9: lane phase, table, folding, packing
        chk(lane(sin_o, k) == es[3][k], $sformatf("R5 sin lane %0d", k), lane(sin_o, k), es[3][k]);
        // R6 cosine a quarter period ahead
        chk(lane(cos_o, k) == ec[3][k], $sformatf("R6 cos lane %0d", k), lane(cos_o, k), ec[3][k]);
      end
      if (ef[3]) begin
        chk(lane(sin_o, 0) == 0, "R7 sin after clear", lane(sin_o, 0), 0);
        chk(lane(cos_o, 0) == FS, "R7 cos after clear", lane(cos_o, 0), FS);
      end
    end
  endtask

  task automatic step(input bit c, input bit e, input int f);
    @(negedge clk);
    compare();
    clr = c; en = e; inc = 16'(f);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(vld == 1'b0, "R1 vld in reset", int'(vld), 0);
    chk(sin_o == '0 && cos_o == '0, "R1 outputs in reset", int'(sin_o != '0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld == 1'b0, "R1 vld after reset", int'(vld), 0);
    chk(sin_o == '0, "R1 sin after reset", int'(sin_o != '0), 0);

    // R7 clear with enable, then steady tone
    step(1, 1, 16'h0400);
    for (int i = 0; i < 40; i++) step(0, 1, 16'h0400);
    // R2 R3 gaps in enable
    for (int i = 0; i < 40; i++) step(0, (i % 3) != 1, 16'h0123);
    // R5 quadrant edges
    step(1, 1, 16'h4000);
    for (int i = 0; i < 12; i++) step(0, 1, 16'h4000);
    // R5 backwards wrap
    for (int i = 0; i < 40; i++) step(0, 1, 16'hFFFF);
    // R8 increment changing every cycle
    for (int i = 0; i < 200; i++) step(0, ($urandom % 5) != 0, int'($urandom & 16'hFFFF));
    // R7 lone clear then enable
    step(1, 0, 16'h0777);
    step(0, 0, 16'h0777);
    step(1, 1, 16'h0777);
    for (int i = 0; i < 20; i++) step(0, 1, 16'h0777);
    // R4 slow sweep through whole table
    step(1, 1, 16'h0010);
    for (int i = 0; i < 1100; i++) step(0, 1, 16'h0010);
    for (int i = 0; i < 6; i++) step(0, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule